// File: doc/BRIEF.md
# Time-Multiplexed Inter-Chip Pin Link

This block sits in every chip of a partitioned emulation system. It lets many logical one-bit signals that cross a chip boundary share a small number of physical pins. Each emulated design clock is divided into V microcycles, and a one-hot sequencer steps through them. A schedule fixed at compile time decides, for every outgoing pin and every microcycle, which local signal the pin carries. It also decides which incoming pin value is captured into which holding register, and which already-captured value is driven again towards a further chip. Driving a value again like this is how routes over several hops are built: each extra hop costs one later microcycle.

A pulse on `frame_start` opens an emulated clock. The local outputs are snapshotted at that moment, so the values sent stay constant while the design logic moves on. The sequencer then runs through microcycles 0 to V-1 and raises `frame_done` for one cycle. Captured values reach `rx_sig` only after that done cycle, so every chip in the system changes its view of remote signals at the same emulated-clock boundary. Both the phased schedule and the overlapped schedule are expressed as maps. The hardware behaves the same for either.

The sequencer has three states: `ST_IDLE`, `ST_RUN` and `ST_DONE`. Its transitions are:
- launch (`ST_IDLE` to `ST_RUN`, on `frame_start`);
- step (`ST_RUN` to `ST_RUN`, shifting the one-hot slot);
- last (`ST_RUN` to `ST_DONE`, after slot V-1);
- commit (`ST_DONE` to `ST_IDLE`).

Top module: `tdm_pin_link`

## Requirements
- R1: After reset, `pin_out`, `rx_sig` and `frame_done` are all 0.
- R2: A `frame_start` seen in `ST_IDLE` starts V consecutive microcycles, slot 0 to slot V-1, beginning in the cycle after the pulse. `frame_done` is high for exactly one cycle, the cycle right after slot V-1, and the sequencer then returns to idle.
- R3: `frame_start` has no effect while a frame is in progress. The frame length and the done timing stay as they are, and no second frame follows.
- R4: Map entries are IW bits wide. The entry for pin p and slot s sits at bit offset (p*V+s)*IW. A send entry k ≥ 1 drives bit k-1 of the snapshotted `tx_sig` onto `pin_out[p]` during slot s. A slot whose send and relay entries are both 0 drives 0. Outside a running frame, every pin drives 0.
- R5: `tx_sig` is snapshotted in the cycle in which `frame_start` is accepted. Changes to `tx_sig` after that do not affect the values sent in that frame.
- R6: A receive entry k ≥ 1 for input pin p and slot s captures `pin_in[p]`, at the end of slot s, into holding register k-1. A receive entry of 0 captures nothing.
- R7: `rx_sig` is loaded from the holding registers at the end of the `frame_done` cycle, and at no other time.
- R8: A relay entry k ≥ 1 for pin p and slot s drives holding register k-1 onto `pin_out[p]` during slot s, but only when the send entry for the same pin and slot is 0. A nonzero send entry takes priority.
- R9: In a chain of chips sharing `frame_start`, every scheduled signal reaches its destination's `rx_sig` unchanged within the same emulated clock, including signals relayed through an intermediate chip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Microcycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Pulse opening an emulated clock |
| tx_sig | input | N_LOC | Local logical signals to send |
| pin_in | input | N_IN | Physical pins from the upstream chip |
| pin_out | output | N_OUT | Physical pins to the downstream chip |
| rx_sig | output | N_RCV | Received logical signals, updated once per emulated clock |
| frame_done | output | 1 | One-cycle pulse after the last microcycle |

## Verification
Two situations are the hardest to reach from the ports. The first is a slot in which a send entry and a relay entry claim the same pin. The second is a start pulse that arrives while a frame is running. The middle chip of a three-chip chain is given a schedule with a deliberate collision on its second pin in the last slot, so the pin shows whether the local signal wins. On every odd frame the bench pulses `frame_start` in slot 1 and then checks that the frame still ends on time. All 256 combinations of the first two chips' local signals are swept. The local inputs are inverted right after each launch, so any value that leaked past the snapshot would show up at the far chips.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'b001,
        ST_RUN  = 3'b010,
        ST_DONE = 3'b100
    } seq_state_e;
endpackage

// File: rtl/tdm_seq.sv
module tdm_seq
    import tdm_pkg::*;
#(
    parameter int V = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    output logic         run,
    output logic [V-1:0] slot,
    output logic         launch,
    output logic         commit
);
    seq_state_e   state, state_nxt;
    logic [V-1:0] slot_nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            slot  <= '0;
        end else begin
            state <= state_nxt;
            slot  <= slot_nxt;
        end
    end

    // transitions: launch, step, last, commit
    always_comb begin
        state_nxt = state;
        slot_nxt  = slot;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nxt = ST_RUN;
                    slot_nxt  = V'(1);
                end
            end
            ST_RUN: begin
                if (slot[V-1]) begin
                    state_nxt = ST_DONE;
                    slot_nxt  = '0;
                end else begin
                    slot_nxt = slot << 1;
                end
            end
            ST_DONE: begin
                state_nxt = ST_IDLE;
            end
            default: begin
                state_nxt = ST_IDLE;
                slot_nxt  = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        run    = (state == ST_RUN);
        commit = (state == ST_DONE);
        launch = (state == ST_IDLE) && start;
    end
endmodule

// File: rtl/tdm_tx_mux.sv
module tdm_tx_mux #(
    parameter int N_OUT = 2,
    parameter int N_LOC = 4,
    parameter int N_RCV = 4,
    parameter int V     = 4,
    parameter int IW    = 8,
    parameter logic [N_OUT*V*IW-1:0] SEND_MAP  = '0,
    parameter logic [N_OUT*V*IW-1:0] RELAY_MAP = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             run,
    input  logic [V-1:0]     slot,
    input  logic [N_LOC-1:0] tx_sig,
    input  logic [N_RCV-1:0] hold,
    output logic [N_OUT-1:0] pin_out
);
    logic [N_LOC-1:0] snap;

    always_ff @(posedge clk) begin
        if (!rst_n)      snap <= '0;
        else if (launch) snap <= tx_sig;
    end

    always_comb begin
        logic [IW-1:0] se;
        logic [IW-1:0] re;
        logic          v;
        for (int p = 0; p < N_OUT; p++) begin
            v = 1'b0;
            for (int s = 0; s < V; s++) begin
                se = SEND_MAP[(p*V+s)*IW +: IW];
                re = RELAY_MAP[(p*V+s)*IW +: IW];
                if (slot[s]) begin
                    for (int k = 0; k < N_LOC; k++)
                        if (se == IW'(k+1)) v = v | snap[k];
                    if (se == '0)
                        for (int k = 0; k < N_RCV; k++)
                            if (re == IW'(k+1)) v = v | hold[k];
                end
            end
            pin_out[p] = run & v;
        end
    end
endmodule

// File: rtl/tdm_rx_capture.sv
module tdm_rx_capture #(
    parameter int N_IN  = 2,
    parameter int N_RCV = 4,
    parameter int V     = 4,
    parameter int IW    = 8,
    parameter logic [N_IN*V*IW-1:0] RECV_MAP = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [V-1:0]     slot,
    input  logic             commit,
    input  logic [N_IN-1:0]  pin_in,
    output logic [N_RCV-1:0] hold,
    output logic [N_RCV-1:0] rx_sig
);
    logic [N_RCV-1:0] hold_d;

    always_comb begin
        hold_d = hold;
        if (run)
            for (int p = 0; p < N_IN; p++)
                for (int s = 0; s < V; s++)
                    if (slot[s])
                        for (int k = 0; k < N_RCV; k++)
                            if (RECV_MAP[(p*V+s)*IW +: IW] == IW'(k+1))
                                hold_d[k] = pin_in[p];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold   <= '0;
            rx_sig <= '0;
        end else begin
            hold <= hold_d;
            if (commit) rx_sig <= hold;
        end
    end
endmodule

// File: rtl/tdm_pin_link.sv
module tdm_pin_link #(
    parameter int N_IN  = 2,
    parameter int N_OUT = 2,
    parameter int N_LOC = 4,
    parameter int N_RCV = 4,
    parameter int V     = 4,
    parameter int IW    = 8,
    parameter logic [N_OUT*V*IW-1:0] SEND_MAP  = '0,
    parameter logic [N_OUT*V*IW-1:0] RELAY_MAP = '0,
    parameter logic [N_IN*V*IW-1:0]  RECV_MAP  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic [N_LOC-1:0] tx_sig,
    input  logic [N_IN-1:0]  pin_in,
    output logic [N_OUT-1:0] pin_out,
    output logic [N_RCV-1:0] rx_sig,
    output logic             frame_done
);
    logic         seq_run;
    logic [V-1:0] seq_slot;
    logic         seq_launch;
    logic         seq_commit;
    logic [N_RCV-1:0] hold;

    tdm_seq #(.V(V)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (frame_start),
        .run    (seq_run),
        .slot   (seq_slot),
        .launch (seq_launch),
        .commit (seq_commit)
    );

    tdm_tx_mux #(
        .N_OUT(N_OUT), .N_LOC(N_LOC), .N_RCV(N_RCV), .V(V), .IW(IW),
        .SEND_MAP(SEND_MAP), .RELAY_MAP(RELAY_MAP)
    ) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (seq_launch),
        .run     (seq_run),
        .slot    (seq_slot),
        .tx_sig  (tx_sig),
        .hold    (hold),
        .pin_out (pin_out)
    );

    tdm_rx_capture #(
        .N_IN(N_IN), .N_RCV(N_RCV), .V(V), .IW(IW), .RECV_MAP(RECV_MAP)
    ) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (seq_run),
        .slot   (seq_slot),
        .commit (seq_commit),
        .pin_in (pin_in),
        .hold   (hold),
        .rx_sig (rx_sig)
    );

    assign frame_done = seq_commit;
endmodule

// File: rtl/tdm_pin_link_chk.sv
module tdm_pin_link_chk #(
    parameter int V     = 4,
    parameter int N_RCV = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic [V-1:0]     slot,
    input logic             frame_done,
    input logic [N_RCV-1:0] rx_sig
);
    assert_onehot_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> ($countones(slot) == 1));

    assert_done_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && slot[V-1]) |=> (frame_done && !run));

    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    assert_no_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !slot[V-1]) |=> run);

    assert_rx_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> $stable(rx_sig));
endmodule

bind tdm_pin_link tdm_pin_link_chk #(.V(V), .N_RCV(N_RCV)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (seq_run),
    .slot       (seq_slot),
    .frame_done (frame_done),
    .rx_sig     (rx_sig)
);

// File: tb/tb_tdm_pin_link.sv
module tb_tdm_pin_link;
    localparam int V  = 4;
    localparam int IW = 8;
    // entry order, lsb first: p0s0 p0s1 p0s2 p0s3 p1s0 p1s1 p1s2 p1s3
    localparam logic [2*V*IW-1:0] A_SEND  = {8'd0,8'd0,8'd6,8'd5, 8'd4,8'd3,8'd2,8'd1};
    localparam logic [2*V*IW-1:0] B_RECV  = {8'd0,8'd0,8'd6,8'd5, 8'd4,8'd3,8'd2,8'd1};
    localparam logic [2*V*IW-1:0] B_SEND  = {8'd1,8'd0,8'd0,8'd0, 8'd0,8'd0,8'd2,8'd1};
    localparam logic [2*V*IW-1:0] B_RELAY = {8'd1,8'd6,8'd5,8'd0, 8'd0,8'd0,8'd0,8'd0};
    localparam logic [2*V*IW-1:0] C_RECV  = {8'd0,8'd4,8'd3,8'd0, 8'd0,8'd0,8'd2,8'd1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0;
    logic [5:0] a_tx = '0;
    logic [1:0] b_tx = '0;
    logic [1:0] a_pins, b_pins, c_pins;
    logic [0:0] a_rx;
    logic [5:0] b_rx;
    logic [3:0] c_rx;
    logic a_done, b_done, c_done;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    tdm_pin_link #(.N_IN(2), .N_OUT(2), .N_LOC(6), .N_RCV(1), .V(V), .IW(IW),
        .SEND_MAP(A_SEND)) u_a (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .tx_sig(a_tx),
        .pin_in(2'b00), .pin_out(a_pins), .rx_sig(a_rx), .frame_done(a_done));

    tdm_pin_link #(.N_IN(2), .N_OUT(2), .N_LOC(2), .N_RCV(6), .V(V), .IW(IW),
        .SEND_MAP(B_SEND), .RELAY_MAP(B_RELAY), .RECV_MAP(B_RECV)) dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .tx_sig(b_tx),
        .pin_in(a_pins), .pin_out(b_pins), .rx_sig(b_rx), .frame_done(b_done));

    tdm_pin_link #(.N_IN(2), .N_OUT(2), .N_LOC(1), .N_RCV(4), .V(V), .IW(IW),
        .RECV_MAP(C_RECV)) u_c (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .tx_sig(1'b0),
        .pin_in(b_pins), .pin_out(c_pins), .rx_sig(c_rx), .frame_done(c_done));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_frame(input int i);
        logic [5:0] a;
        logic [1:0] b;
        logic [5:0] prev_b;
        logic [3:0] prev_c;
        logic [1:0] ea, eb;
        a = i[5:0];
        b = i[7:6];
        prev_b = b_rx;
        prev_c = c_rx;
        @(negedge clk);
        a_tx = a; b_tx = b; frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        a_tx = ~a; b_tx = ~b;           // R5: must not reach the pins this frame
        for (int s = 0; s < V; s++) begin
            ea[0] = a[s];
            ea[1] = (s == 0) ? a[4] : (s == 1) ? a[5] : 1'b0;
            eb[0] = (s == 0) ? b[0] : (s == 1) ? b[1] : 1'b0;
            eb[1] = (s == 1) ? a[4] : (s == 2) ? a[5] : (s == 3) ? b[0] : 1'b0;
            chk("R4 send pins chip A", {6'd0, a_pins}, {6'd0, ea});
            chk("R5 snapshot pins chip B pin0", {7'd0, b_pins[0]}, {7'd0, eb[0]});
            chk("R8 relay and send priority chip B pin1", {7'd0, b_pins[1]}, {7'd0, eb[1]});
            chk("R2 no done during slots", {7'd0, b_done}, 8'd0);
            if (s == 2) begin
                chk("R7 rx_sig held mid-frame B", {2'd0, b_rx}, {2'd0, prev_b});
                chk("R7 rx_sig held mid-frame C", {4'd0, c_rx}, {4'd0, prev_c});
            end
            if (s == 1 && i[0]) frame_start = 1'b1;   // R3 stimulus
            if (s == 2) frame_start = 1'b0;
            @(negedge clk);
        end
        chk("R2 done after last slot", {5'd0, a_done, b_done, c_done}, 8'd7);
        chk("R7 rx_sig not yet loaded", {2'd0, b_rx}, {2'd0, prev_b});
        @(negedge clk);
        chk("R2 done one cycle", {7'd0, b_done}, 8'd0);
        chk("R3 idle after frame, pins 0", {4'd0, a_pins, b_pins}, 8'd0);
        chk("R6 capture at chip B", {2'd0, b_rx}, {2'd0, a});
        chk("R9 end-to-end incl. relay at chip C", {4'd0, c_rx}, {4'd0, a[5], a[4], b[1], b[0]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset pins", {4'd0, a_pins, b_pins}, 8'd0);
        chk("R1 reset rx", {1'd0, c_rx, a_rx, b_rx[2:0]}, 8'd0);
        chk("R1 reset done", {5'd0, a_done, b_done, c_done}, 8'd0);
        for (int i = 0; i < 256; i++) run_frame(i);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule